// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single counter channel of a six-mode interval timer. It sits in a synchronous clock domain. A one-cycle `tick` enable advances an internal elapsed-tick counter, which measures how many ticks have passed since the count was last loaded. The output bit is decoded from that counter, the loaded count and the selected mode. Depending on the mode, the channel acts as a terminal-count flag, a retriggerable one-shot, a rate generator, a square-wave generator, or a single-tick strobe.

Software writes a mode and a count together in one cycle through a simple configuration port. A count of zero means 65536. A gate input can freeze counting, or restart counting, depending on the mode. A status port reports the channel's present configuration and output level. A look-ahead pair reports how many more counted ticks remain until the output next changes level, or reports that no further change will come. A scheduler can use this to skip idle ticks.

Top module: `pit_channel`

## Requirements
- R1: Modes are encoded 0 to 5 on `cfgMode`. A write of 6 or 7 stores mode 0, reads back as 0 on `statMode`, and behaves as mode 0.
- R2: In mode 0, `outBit` is low while the elapsed count `d` is below the loaded count `N`. It is high from `d >= N` onward.
- R3: In mode 1, `outBit` is high while `d < N` and low once `d >= N`.
- R4: In mode 2, `outBit` is high exactly when `d` is a nonzero multiple of `N`, and low otherwise.
- R5: In mode 3, `outBit` is high while `d mod N < (N+1)>>1` and low for the rest of each period of `N` ticks.
- R6: In modes 4 and 5, `outBit` is high only when `d == N`.
- R7: A written count of 0 loads `N = 65536`, which reads back on the 17-bit `statCount` as 0x10000.
- R8: After reset, the channel is in mode 3 with `N = 65536` and `d = 0`, and `statGate` equals the `GATE_RESET` parameter.
- R9: A write sets `d` to 0 at the clock edge where `cfgWr` is high. The next counted tick makes `d = 1`.
- R10: In modes 0, 2, 3 and 4, a tick is counted only while `gateIn` is high. With the gate low, `d` and `outBit` hold.
- R11: In modes 1 and 5, a low-to-high step of `gateIn` between two clocks sets `d` to 0. Ticks are counted whatever the gate level.
- R12: In modes 0, 1, 4 and 5, `d` saturates instead of wrapping, so `outBit` holds its final level for as long as ticks continue.
- R13: `nextValid` is high with `nextDist = k` when `outBit` will change after `k` more counted ticks. `nextValid` is low when no change remains: modes 0 and 1 once `d >= N`, modes 4 and 5 once `d > N`, and modes 2 and 3 with `N = 1` once the output is constant.
- R14: `statMode`, `statCount` and `statGate` reflect the stored mode, the loaded count and the gate level sampled at the last clock. `statOut` equals `outBit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle count enable |
| cfgWr | input | 1 | Load `cfgMode` and `cfgCount`, and clear the elapsed count |
| cfgMode | input | 3 | Mode number to load |
| cfgCount | input | CNT_W (16) | Count to load; 0 means 2^CNT_W |
| gateIn | input | 1 | Gate level |
| outBit | output | 1 | Channel output waveform |
| statMode | output | 3 | Stored mode |
| statGate | output | 1 | Registered gate level |
| statCount | output | CNT_W+1 (17) | Loaded count |
| statOut | output | 1 | Present output level |
| nextValid | output | 1 | A future output change exists |
| nextDist | output | CNT_W+1 (17) | Counted ticks until that change |

## Verification
Directed runs step each mode through small counts, including counts of 1 and 2. These show the modes apart by the position and the length of their high phases, and they expose off-by-one errors in the half-period and multiple-of-count tests. Separate gate patterns are used to tell the two gate behaviours apart: holding the gate low with ticks arriving, and stepping it low and then high. Freeze modes must hold their output, and restart modes must begin their pulse again. Long random sequences mix writes of every mode value, including the undefined ones and a zero count, with random tick and gate activity. A reference built on elapsed-count arithmetic checks the output, the status fields and the look-ahead distance after every clock.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    MODE_TERM     = 3'd0,
    MODE_ONESHOT  = 3'd1,
    MODE_RATE     = 3'd2,
    MODE_SQUARE   = 3'd3,
    MODE_SWSTROBE = 3'd4,
    MODE_HWSTROBE = 3'd5
  } pitMode_e;

  typedef struct packed {
    logic clear;     // elapsed count back to zero
    logic advance;   // count one tick
    logic periodic;  // wrap at the loaded count instead of saturating
  } pitStrobe_t;

  function automatic pitMode_e legalMode(input logic [2:0] raw);
    return (raw > 3'd5) ? MODE_TERM : pitMode_e'(raw);
  endfunction

  function automatic logic gateRestarts(input pitMode_e m);
    return (m == MODE_ONESHOT) || (m == MODE_HWSTROBE);
  endfunction

  function automatic logic isPeriodic(input pitMode_e m);
    return (m == MODE_RATE) || (m == MODE_SQUARE);
  endfunction

endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int   CNT_W      = 16,
  parameter logic GATE_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfgWr,
  input  logic [2:0]       cfgMode,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             gateIn,
  output pitMode_e         modeQ,
  output logic [CNT_W:0]   countQ,
  output logic             gateQ,
  output pitStrobe_t       stb
);

  localparam logic [CNT_W:0] FULL_COUNT = {1'b1, {CNT_W{1'b0}}};

  logic [CNT_W:0] loadCount;
  logic           gateRise;
  logic           restartMode;

  assign loadCount = (cfgCount == '0) ? FULL_COUNT : {1'b0, cfgCount};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ  <= MODE_SQUARE;
      countQ <= FULL_COUNT;
      gateQ  <= GATE_RESET;
    end else begin
      gateQ <= gateIn;
      if (cfgWr) begin
        modeQ  <= legalMode(cfgMode);
        countQ <= loadCount;
      end
    end
  end

  always_comb begin
    restartMode  = gateRestarts(modeQ);
    gateRise     = gateIn & ~gateQ;
    stb.clear    = cfgWr | (gateRise & restartMode);
    stb.advance  = tick & ~stb.clear & (gateIn | restartMode);
    stb.periodic = isPeriodic(modeQ);
  end

  // R1: the stored mode never holds an undefined code
  assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    modeQ <= MODE_HWSTROBE);

  // R7: the loaded count is never zero
  assert_count_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    countQ != '0);

  // R7: a zero write lands as the full count
  assert_zero_loads_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWr && cfgCount == '0) |=> countQ == FULL_COUNT);

endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  pitStrobe_t     stb,
  input  pitMode_e       modeQ,
  input  logic [CNT_W:0] countQ,
  output logic           outBit,
  output logic           nextValid,
  output logic [CNT_W:0] nextDist
);

  localparam int            EW       = CNT_W + 2;
  localparam logic [EW-1:0] ELAP_MAX = {EW{1'b1}};
  localparam logic [EW-1:0] ONE      = EW'(1);

  logic [EW-1:0] elap;      // elapsed ticks, or phase in the periodic modes
  logic          wrapped;   // a full period has completed since the clear
  logic [EW-1:0] nExt;
  logic [EW-1:0] lastPhase;
  logic [EW-1:0] half;
  logic [EW-1:0] distW;

  assign nExt      = EW'(countQ);
  assign lastPhase = nExt - ONE;
  assign half      = (nExt + ONE) >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elap    <= '0;
      wrapped <= 1'b0;
    end else if (stb.clear) begin
      elap    <= '0;
      wrapped <= 1'b0;
    end else if (stb.advance) begin
      if (stb.periodic) begin
        if (elap >= lastPhase) begin
          elap    <= '0;
          wrapped <= 1'b1;
        end else begin
          elap <= elap + ONE;
        end
      end else if (elap != ELAP_MAX) begin
        elap <= elap + ONE;
      end
    end
  end

  always_comb begin
    case (modeQ)
      MODE_ONESHOT:                 outBit = (elap < nExt);
      MODE_RATE:                    outBit = (elap == '0) && wrapped;
      MODE_SQUARE:                  outBit = (elap < half);
      MODE_SWSTROBE, MODE_HWSTROBE: outBit = (elap == nExt);
      default:                      outBit = (elap >= nExt);
    endcase
  end

  always_comb begin
    nextValid = 1'b0;
    distW     = '0;
    case (modeQ)
      MODE_SWSTROBE, MODE_HWSTROBE: begin
        if (elap < nExt) begin
          nextValid = 1'b1;
          distW     = nExt - elap;
        end else if (elap == nExt) begin
          nextValid = 1'b1;
          distW     = ONE;
        end
      end
      MODE_RATE: begin
        if (nExt == ONE) begin
          nextValid = ~wrapped;
          distW     = ONE;
        end else begin
          nextValid = 1'b1;
          distW     = outBit ? ONE : (nExt - elap);
        end
      end
      MODE_SQUARE: begin
        if (nExt != ONE) begin
          nextValid = 1'b1;
          distW     = (elap < half) ? (half - elap) : (nExt - elap);
        end
      end
      default: begin
        if (elap < nExt) begin
          nextValid = 1'b1;
          distW     = nExt - elap;
        end
      end
    endcase
    nextDist = distW[CNT_W:0];
  end

  // R5: the phase of a periodic mode stays inside one period
  assert_phase_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    isPeriodic(modeQ) |-> elap < nExt);

  // R9: a clear strobe leaves the counter at zero on the next cycle
  assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clear |=> (elap == '0) && !wrapped);

  // R12: one-shot counting never wraps back down
  assert_no_wrap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.advance && !stb.periodic) |=> elap >= $past(elap));

  // R2: once high in mode 0 the output stays high until a clear
  assert_latched_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_TERM && outBit && !stb.clear) |=> outBit);

  // R6: a strobe lasts one counted tick
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((modeQ == MODE_SWSTROBE || modeQ == MODE_HWSTROBE) && outBit && stb.advance)
      |=> !outBit);

  // R13: a distance of one means the next counted tick flips the output
  assert_next_due_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (nextValid && nextDist == 1 && stb.advance) |=> outBit != $past(outBit));

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int   CNT_W      = 16,
  parameter logic GATE_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfgWr,
  input  logic [2:0]       cfgMode,
  input  logic [CNT_W-1:0] cfgCount,
  input  logic             gateIn,
  output logic             outBit,
  output logic [2:0]       statMode,
  output logic             statGate,
  output logic [CNT_W:0]   statCount,
  output logic             statOut,
  output logic             nextValid,
  output logic [CNT_W:0]   nextDist
);

  pitMode_e       modeQ;
  logic [CNT_W:0] countQ;
  logic           gateQ;
  pitStrobe_t     stb;
  logic           outInt;

  pit_ctrl #(.CNT_W(CNT_W), .GATE_RESET(GATE_RESET)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cfgWr    (cfgWr),
    .cfgMode  (cfgMode),
    .cfgCount (cfgCount),
    .gateIn   (gateIn),
    .modeQ    (modeQ),
    .countQ   (countQ),
    .gateQ    (gateQ),
    .stb      (stb)
  );

  pit_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .modeQ     (modeQ),
    .countQ    (countQ),
    .outBit    (outInt),
    .nextValid (nextValid),
    .nextDist  (nextDist)
  );

  assign outBit    = outInt;
  assign statOut   = outInt;
  assign statMode  = modeQ;
  assign statGate  = gateQ;
  assign statCount = countQ;

endmodule

// File: tb/pit_channel_bench.sv
module pit_channel_bench;

  localparam int CNT_W = 16;
  localparam int FULL  = 65536;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic             cfgWr = 1'b0;
  logic [2:0]       cfgMode = '0;
  logic [CNT_W-1:0] cfgCount = '0;
  logic             gateIn = 1'b1;
  logic             outBit, statGate, statOut, nextValid;
  logic [2:0]       statMode;
  logic [CNT_W:0]   statCount, nextDist;

  int  total = 0;
  int  fails = 0;
  bit  done  = 0;

  // reference state
  int     mMode = 3;
  int     mN    = FULL;
  longint mD    = 0;
  bit     mGate = 1;

  always #5 clk = ~clk;

  pit_channel #(.CNT_W(CNT_W), .GATE_RESET(1'b1)) u_pit_channel (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfgWr(cfgWr), .cfgMode(cfgMode),
    .cfgCount(cfgCount), .gateIn(gateIn), .outBit(outBit), .statMode(statMode),
    .statGate(statGate), .statCount(statCount), .statOut(statOut),
    .nextValid(nextValid), .nextDist(nextDist)
  );

  function automatic bit refOut(int m, int n, longint d);
    case (m)
      1:       return d < n;
      2:       return (d % n == 0) && (d != 0);
      3:       return (d % n) < ((n + 1) / 2);
      4, 5:    return d == n;
      default: return d >= n;
    endcase
  endfunction

  function automatic int refNext(int m, int n, longint d);
    bit now = refOut(m, n, d);
    for (int k = 1; k <= 2 * n + 2; k++)
      if (refOut(m, n, d + k) != now) return k;
    return 0;
  endfunction

  function automatic string outTag(int m);
    case (m)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4, 5: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll();
    bit eo = refOut(mMode, mN, mD);
    chk(outBit == eo, outTag(mMode), "outBit", outBit, eo);
    chk(statOut == outBit, "R14", "statOut", statOut, outBit);
    chk(statMode == mMode[2:0], "R14", "statMode", statMode, mMode);
    chk(statCount == mN[CNT_W:0], "R14", "statCount", statCount, mN);
    chk(statGate == mGate, "R14", "statGate", statGate, mGate);
    if (mN <= 300) begin
      int en = refNext(mMode, mN, mD);
      chk(nextValid == (en != 0), "R13", "nextValid", nextValid, en != 0);
      if (en != 0) chk(nextDist == en[CNT_W:0], "R13", "nextDist", nextDist, en);
    end
  endtask

  task automatic cyc(bit wr, int m, int c, bit g, bit t);
    cfgWr = wr; cfgMode = m[2:0]; cfgCount = c[CNT_W-1:0]; gateIn = g; tick = t;
    @(posedge clk);
    if (wr) begin
      mMode = (m > 5) ? 0 : m;
      mN    = (c == 0) ? FULL : c;
      mD    = 0;
    end else if (g && !mGate && (mMode == 1 || mMode == 5)) begin
      mD = 0;
    end else if (t && (g || mMode == 1 || mMode == 5)) begin
      mD++;
    end
    mGate = g;
    @(negedge clk);
    cfgWr = 0;
    checkAll();
  endtask

  task automatic ticks(int k, bit g);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, g, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
      $finish;
    end
  end

  initial begin
    bit held;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    chk(statMode == 3, "R8", "reset mode", statMode, 3);
    chk(statCount == FULL, "R8", "reset count", statCount, FULL);
    chk(statGate == 1, "R8", "reset gate", statGate, 1);
    chk(outBit == 1, "R8", "reset out", outBit, 1);
    chk(nextValid && nextDist == 32768, "R8", "reset nextDist", nextDist, 32768);

    // R2 mode 0
    cyc(1, 0, 5, 1, 0); ticks(8, 1);
    // R1 undefined mode behaves as mode 0
    cyc(1, 6, 4, 1, 0);
    chk(statMode == 0, "R1", "mode 6 readback", statMode, 0);
    ticks(6, 1);
    cyc(1, 7, 2, 1, 0);
    chk(statMode == 0, "R1", "mode 7 readback", statMode, 0);
    ticks(3, 1);
    // R3 mode 1 and R11 gate restart
    cyc(1, 1, 4, 1, 0); ticks(6, 1);
    chk(outBit == 0, "R3", "one-shot expired", outBit, 0);
    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 1, 0);
    chk(outBit == 1, "R11", "gate restart", outBit, 1);
    ticks(2, 0);
    chk(outBit == 1, "R11", "counts with gate low", outBit, 1);
    chk(nextDist == 2, "R11", "dist after gate-low ticks", nextDist, 2);
    ticks(4, 1);
    // R4 mode 2
    cyc(1, 2, 3, 1, 0); ticks(10, 1);
    cyc(1, 2, 1, 1, 0); ticks(4, 1);
    // R5 mode 3 with odd, 1 and 2 counts
    cyc(1, 3, 5, 1, 0); ticks(12, 1);
    cyc(1, 3, 1, 1, 0); ticks(3, 1);
    cyc(1, 3, 2, 1, 0); ticks(5, 1);
    // R6 modes 4 and 5
    cyc(1, 4, 3, 1, 0); ticks(8, 1);
    cyc(1, 5, 2, 1, 0); ticks(4, 1);
    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 1, 0); ticks(3, 1);
    // R7 zero count
    cyc(1, 0, 0, 1, 0);
    chk(statCount == FULL, "R7", "zero count readback", statCount, FULL);
    chk(nextValid && nextDist == FULL, "R7", "zero count distance", nextDist, FULL);
    // R10 gate freeze
    cyc(1, 3, 4, 1, 0); ticks(1, 1);
    held = outBit;
    ticks(5, 0);
    chk(outBit == held, "R10", "frozen output", outBit, held);
    chk(nextDist == 1, "R10", "frozen distance", nextDist, 1);
    ticks(3, 1);
    // R9 write clears the elapsed count
    cyc(1, 0, 3, 1, 0); ticks(2, 1);
    cyc(1, 0, 3, 1, 1);
    chk(nextDist == 3, "R9", "distance after rewrite", nextDist, 3);
    ticks(1, 1);
    chk(nextDist == 2, "R9", "first tick after rewrite", nextDist, 2);
    // R12 one-shot saturation
    cyc(1, 1, 2, 1, 0); ticks(30, 1);
    chk(outBit == 0 && !nextValid, "R12", "final level held", outBit, 0);

    // random mix
    for (int i = 0; i < 2500; i++) begin
      bit wr = ($urandom % 25) == 0;
      int m  = $urandom % 8;
      int c  = $urandom % 21;
      bit g  = (($urandom % 8) == 0) ? ~gateIn : gateIn;
      bit t  = $urandom % 2;
      cyc(wr, m, c, g, t);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end

endmodule